// File: doc/BRIEF.md
# Pulse-Swallow Integer Feedback Divider

This block is a cycle-accurate digital model of the main feedback divider in an integer-N frequency synthesizer. It runs on the fast input clock. Every clock cycle of the block is one input cycle. A dual-modulus prescaler divides by ten or by eleven. A main counter counts the prescaler cycles, and a swallow counter decides for how many of those cycles the prescaler uses eleven. Together they give an overall integer ratio of 10·(M+1)+A. In bypass mode the prescaler and the swallow counter drop out, and the main counter divides the input directly by M+1.

New settings are offered with a single-cycle load strobe. A legal setting is held as pending and becomes active only at the end of the period that is running, so no period mixes two settings. An illegal setting (M of zero, or A above M+1) is discarded and raises a sticky error flag. The divider keeps running on the last legal setting. The block produces a one-cycle pulse on the final input cycle of every division period. The modulus-select line is visible as an output.

Top module: `pswallow_div`

## Requirements
- R1: During reset and after it, `fp`, `mod_sel` and `param_err` are 0. The first period after reset uses the default setting M=1, A=0, normal mode, and so lasts 20 input cycles, counted from the first cycle with reset low.
- R2: With bypass low, successive `fp` pulses are exactly 10·(M+1)+A input cycles apart.
- R3: `fp` is high for exactly one input cycle per period, on the last cycle of that period.
- R4: With bypass low, `mod_sel` (1 = divide by eleven) is high for the first 11·A input cycles of each period and low for the rest of it. When A=0 it stays low for the whole period.
- R5: With bypass high, successive `fp` pulses are M+1 cycles apart and `mod_sel` stays 0. The value of A has no effect on the ratio.
- R6: A legal setting loaded part way through a period does not change the length of that period. It governs every period after the next `fp`.
- R7: A load with M=0 or with A>M+1 sets `param_err` on the next cycle. The flag stays set until reset. The rejected setting never becomes active.
- R8: M=1 is the smallest main ratio: in bypass mode it gives a period of 2, and with A=2 in normal mode it gives 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; one edge per input cycle |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe that offers `m_val`, `a_val`, `bypass` |
| m_val | input | 9 | Main counter value M (legal 1..511) |
| a_val | input | 4 | Swallow counter value A (legal 0..M+1) |
| bypass | input | 1 | 1 = skip the prescaler, divide by M+1 |
| fp | output | 1 | One-cycle pulse on the last input cycle of each period |
| mod_sel | output | 1 | Prescaler modulus: 1 = divide by 11, 0 = divide by 10 |
| param_err | output | 1 | Sticky flag for a rejected setting |

## Verification
A prescaler phase that slips moves the next `fp` by one or more cycles. So does a main count that is off by one. Either fault appears as a period-length mismatch at the first pulse after the fault, within one period. A swallow counter that miscounts changes how many cycles `mod_sel` is high within that same period, even where the total length happens to survive. A setting taken in at the wrong moment lengthens or shortens the period in which the load occurred, and that mismatch appears at the very next pulse.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int M_W   = 9;
    localparam int A_W   = 4;
    localparam int PS_LO = 10;
    localparam int PS_HI = 11;
    localparam int PC_W  = $clog2(PS_HI);

    typedef struct packed {
        logic           byp;
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
    } div_cfg_t;

    function automatic logic cfg_legal(div_cfg_t c);
        return (c.m != '0) && (32'(c.a) <= 32'(c.m) + 32'd1);
    endfunction

endpackage

// File: rtl/psd_cfg_bank.sv
module psd_cfg_bank
    import psd_pkg::*;
#(
    parameter div_cfg_t RST_CFG = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t wr_cfg,
    input  logic     boundary,
    output div_cfg_t act_cfg,
    output logic     param_err
);

    div_cfg_t pend_cfg;
    logic     pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg   <= RST_CFG;
            pend_cfg  <= '0;
            pend_vld  <= 1'b0;
            param_err <= 1'b0;
        end else begin
            if (boundary && pend_vld) begin
                act_cfg  <= pend_cfg;
                pend_vld <= 1'b0;
            end
            if (load) begin
                if (cfg_legal(wr_cfg)) begin
                    pend_cfg <= wr_cfg;
                    pend_vld <= 1'b1;
                end else begin
                    param_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/psd_prescale.sv
module psd_prescale
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic byp,
    input  logic mod_hi,
    output logic tick
);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] pc_last;

    assign pc_last = mod_hi ? PC_W'(PS_HI - 1) : PC_W'(PS_LO - 1);
    assign tick    = byp || (pc == pc_last);

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/psd_chain.sv
module psd_chain
    import psd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  div_cfg_t act_cfg,
    output logic     fp,
    output logic     mod_hi
);

    logic [M_W-1:0] mc;
    logic [A_W-1:0] swallowed;

    assign fp     = tick && (mc == act_cfg.m);
    assign mod_hi = !act_cfg.byp && (swallowed < act_cfg.a);

    always_ff @(posedge clk) begin
        if (rst || fp) begin
            mc        <= '0;
            swallowed <= '0;
        end else if (tick) begin
            mc <= mc + 1'b1;
            if (mod_hi) begin
                swallowed <= swallowed + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import psd_pkg::*;
#(
    parameter int DEF_M = 1,
    parameter int DEF_A = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           bypass,
    output logic           fp,
    output logic           mod_sel,
    output logic           param_err
);

    localparam div_cfg_t RST_CFG = '{byp: 1'b0, a: A_W'(DEF_A), m: M_W'(DEF_M)};

    div_cfg_t wr_cfg;
    div_cfg_t act_cfg;
    logic     tick;

    assign wr_cfg = '{byp: bypass, a: a_val, m: m_val};

    psd_cfg_bank #(.RST_CFG(RST_CFG)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .wr_cfg    (wr_cfg),
        .boundary  (fp),
        .act_cfg   (act_cfg),
        .param_err (param_err)
    );

    psd_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .byp    (act_cfg.byp),
        .mod_hi (mod_sel),
        .tick   (tick)
    );

    psd_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .act_cfg (act_cfg),
        .fp      (fp),
        .mod_hi  (mod_sel)
    );

endmodule

// File: rtl/psd_chk.sv
module psd_chk
    import psd_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     fp,
    input logic     mod_sel,
    input logic     param_err,
    input div_cfg_t act
);

    // R3: the output pulse never lasts two cycles
    a_r3_fp_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fp |=> !fp);

    // R4: a new period opens with the modulus the active setting calls for
    a_r4_period_opens_mod: assert property (@(posedge clk) disable iff (rst)
        fp |=> (mod_sel == (!act.byp && act.a != '0)));

    // R5: bypass keeps the modulus select low
    a_r5_bypass_no_mod: assert property (@(posedge clk) disable iff (rst)
        act.byp |-> !mod_sel);

    // R6: the active setting moves only right after a period boundary
    a_r6_cfg_only_at_edge: assert property (@(posedge clk) disable iff (rst)
        !$past(fp) |-> $stable(act));

    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        param_err |=> param_err);

    // R7: a rejected setting never becomes active
    a_r7_act_legal: assert property (@(posedge clk) disable iff (rst)
        cfg_legal(act));

endmodule

bind pswallow_div psd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fp        (fp),
    .mod_sel   (mod_sel),
    .param_err (param_err),
    .act       (act_cfg)
);

// File: tb/test_pswallow_div.sv
module test_pswallow_div;

    typedef struct packed {
        logic [8:0]  m;
        logic [3:0]  a;
        logic        byp;
        logic [12:0] len;
        logic [7:0]  hi;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{9'd1,   4'd0,  1'b0, 13'd20,   8'd0},
        '{9'd1,   4'd2,  1'b0, 13'd22,   8'd22},
        '{9'd5,   4'd6,  1'b0, 13'd66,   8'd66},
        '{9'd9,   4'd9,  1'b0, 13'd109,  8'd99},
        '{9'd511, 4'd15, 1'b0, 13'd5135, 8'd165},
        '{9'd1,   4'd0,  1'b1, 13'd2,    8'd0},
        '{9'd511, 4'd0,  1'b1, 13'd512,  8'd0},
        '{9'd20,  4'd15, 1'b1, 13'd21,   8'd0},
        '{9'd3,   4'd4,  1'b0, 13'd44,   8'd44},
        '{9'd100, 4'd0,  1'b0, 13'd1010, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [8:0] m_val = '0;
    logic [3:0] a_val = '0;
    logic       bypass = 1'b0;
    logic       fp;
    logic       mod_sel;
    logic       param_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pswallow_div i_pswallow_div (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .m_val     (m_val),
        .a_val     (a_val),
        .bypass    (bypass),
        .fp        (fp),
        .mod_sel   (mod_sel),
        .param_err (param_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fp();
        do @(negedge clk); while (!fp);
    endtask

    // call at a negedge where fp was seen; returns the length of the next period
    task automatic measure(output int len, output int hi, output int first_fp);
        len = 0;
        hi = 0;
        first_fp = 0;
        do begin
            @(negedge clk);
            len++;
            if (mod_sel) hi++;
            if (len == 1) first_fp = int'(fp);
        end while (!fp);
    endtask

    task automatic apply(input int m, input int a, input bit byp);
        @(negedge clk);
        m_val = 9'(m);
        a_val = 4'(a);
        bypass = byp;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_fp();
    endtask

    task automatic run_vec(input int m, input int a, input bit byp,
                           input int exp_len, input int exp_hi, input string tag);
        int len, hi, ff;
        apply(m, a, byp);
        measure(len, hi, ff);
        check(len == exp_len, byp ? {"R5 ratio ", tag} : {"R2 ratio ", tag}, len, exp_len);
        check(hi == exp_hi, byp ? {"R5 mod_sel ", tag} : {"R4 mod_sel ", tag}, hi, exp_hi);
        check(ff == 0, {"R3 pulse width ", tag}, ff, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int len, hi, ff;
        int m, a, exp_len, exp_hi;
        bit b;

        // R1: reset state and first period
        repeat (4) @(negedge clk);
        check(fp == 1'b0, "R1 fp in reset", int'(fp), 0);
        check(mod_sel == 1'b0, "R1 mod_sel in reset", int'(mod_sel), 0);
        check(param_err == 1'b0, "R1 param_err in reset", int'(param_err), 0);
        rst = 1'b0;
        len = 1;
        while (!fp) begin
            @(negedge clk);
            len++;
        end
        check(len == 20, "R1 first period", len, 20);
        check(param_err == 1'b0, "R1 param_err after reset", int'(param_err), 0);

        // table of vectors (entries 1 and 5 are the R8 minimum-ratio cases)
        for (int i = 0; i < NV; i++) begin
            run_vec(int'(VECS[i].m), int'(VECS[i].a), VECS[i].byp,
                    int'(VECS[i].len), int'(VECS[i].hi),
                    (i == 1 || i == 5) ? "R8" : "vec");
        end

        // randomized legal settings
        for (int i = 0; i < 20; i++) begin
            m = 1 + int'($urandom % 64);
            a = int'($urandom % (((m + 2) < 16) ? (m + 2) : 16));
            b = (($urandom % 4) == 0);
            exp_len = b ? (m + 1) : (10 * (m + 1) + a);
            exp_hi = b ? 0 : 11 * a;
            run_vec(m, a, b, exp_len, exp_hi, "rand");
        end

        // R6: a load in mid-period leaves that period alone
        run_vec(4, 3, 1'b0, 53, 33, "R6 base");
        len = 0;
        repeat (3) begin
            @(negedge clk);
            len++;
        end
        m_val = 9'd2;
        a_val = 4'd0;
        bypass = 1'b0;
        load = 1'b1;
        @(negedge clk);
        len++;
        load = 1'b0;
        while (!fp) begin
            @(negedge clk);
            len++;
        end
        check(len == 53, "R6 current period kept", len, 53);
        measure(len, hi, ff);
        check(len == 30, "R6 next period new", len, 30);

        // R7: illegal M
        @(negedge clk);
        m_val = 9'd0;
        a_val = 4'd0;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(param_err == 1'b1, "R7 err on M=0", int'(param_err), 1);
        wait_fp();
        measure(len, hi, ff);
        check(len == 30, "R7 M=0 ignored", len, 30);

        // R7: A above M+1
        apply(2, 4, 1'b0);
        measure(len, hi, ff);
        check(len == 30, "R7 A>M+1 ignored", len, 30);
        check(hi == 0, "R7 A>M+1 mod_sel", hi, 0);

        // R7: flag survives a legal load
        run_vec(3, 1, 1'b0, 41, 11, "R7 legal after err");
        check(param_err == 1'b1, "R7 err sticky", int'(param_err), 1);

        // R1: reset clears the flag
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(param_err == 1'b0, "R1 err cleared by reset", int'(param_err), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule